// File: doc/BRIEF.md
# Rail and Thermal Fault Monitor

This block watches the supply health and temperatures of a system while it runs. It takes three power-good lines, a flag that says the management bus has lost contact with the analog companion chip, and three 8-bit temperature readings. Each reading has its own programmable trip level. When any of these goes wrong, the block records a one-byte error code and a severity class. It then asks the system to shut down.

Only the first fault counts. Once a code is held, it stays until reset, even if other faults arrive later. Fault sources are sampled through one register stage. A priority encoder then picks the winning source and loads it into the code register. The shutdown request follows one cycle after that.

Top module: `rail_thermal_monitor`

## Requirements
- R1: After reset, errCode is 0x00, errClass is 0 (none) and shutdownReq is low.
- R2: While runEnable is high, a low railGood bit gives a fatal fault (errClass 1). Bit 0 is the main 12 V supply and gives code 0x01. Bit 1 is the CPU core supply and gives 0x02. Bit 2 is the GPU core supply and gives 0x03.
- R3: A high busLost gives code 0x04 with fatal class. This happens whether runEnable is high or low.
- R4: A temperature strictly above its trip level gives a thermal fault (errClass 2). The sensors map as follows: sensor 0 (CPU) gives 0x05, sensor 1 (GPU) gives 0x06 and sensor 2 (embedded DRAM) gives 0x07. A temperature equal to its trip level is not a fault.
- R5: While runEnable is low, the railGood inputs are ignored. Low power-good lines raise no code.
- R6: When several fault conditions first appear in the same cycle, the lowest code number is recorded.
- R7: The first recorded code and class are held until reset. Later faults do not change them.
- R8: The code appears on the second rising edge after the fault appears at the inputs. shutdownReq goes high one cycle after the code appears and stays high until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| runEnable | input | 1 | High while the system is running; qualifies the power-good lines |
| railGood | input | 3 | Power-good lines: bit 0 main 12 V, bit 1 CPU core, bit 2 GPU core |
| busLost | input | 1 | Companion chip no longer answers on the management bus |
| tempIn | input | 3x8 | Temperature readings: [0] CPU, [1] GPU, [2] embedded DRAM |
| tripLevel | input | 3x8 | Trip thresholds, one for each temperature reading |
| errCode | output | 8 | Recorded error code, 0x00 when no fault is held |
| errClass | output | 2 | 0 none, 1 fatal, 2 thermal |
| shutdownReq | output | 1 | Shutdown request, sticky until reset |

## Verification
Two things can happen in the same cycle: the priority choice among simultaneous faults, and the first-fault latch. Directed cases raise a rail fault, bus loss and an over-temperature together in one cycle. Random cases then drive whole vectors of rail, bus and temperature conditions at once, so many trials start with several sources active in the same cycle. In each trial a bench function computes the lowest active code from the inputs. The recorded code and class must match that value, and must not move when a different fault follows. Threshold equality and power-good with runEnable low are checked directly, since neither may produce a code.

// File: rtl/fault_mon_pkg.sv
`timescale 1ns/1ps
package fault_mon_pkg;

  localparam int SEL_W = 4;

  typedef enum logic [1:0] {
    CLS_NONE    = 2'd0,
    CLS_FATAL   = 2'd1,
    CLS_THERMAL = 2'd2
  } err_class_e;

  // strobes from control to datapath
  typedef struct packed {
    logic             capture;
    logic [SEL_W-1:0] selIdx;
  } latch_ctl_t;

endpackage

// File: rtl/fault_datapath.sv
`timescale 1ns/1ps
module fault_datapath
  import fault_mon_pkg::*;
#(
  parameter int NUM_RAILS   = 3,
  parameter int NUM_SENSORS = 3,
  parameter int TEMP_W      = 8,
  parameter int CODE_W      = 8,
  localparam int FAULT_N    = NUM_RAILS + 1 + NUM_SENSORS,
  localparam int BUS_IDX    = NUM_RAILS
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  logic                               runEnable,
  input  logic [NUM_RAILS-1:0]               railGood,
  input  logic                               busLost,
  input  logic [NUM_SENSORS-1:0][TEMP_W-1:0] tempIn,
  input  logic [NUM_SENSORS-1:0][TEMP_W-1:0] tripLevel,
  input  latch_ctl_t                         ctl,
  output logic [FAULT_N-1:0]                 faultVec,
  output logic [CODE_W-1:0]                  errCode,
  output logic [1:0]                         errClass
);

  logic [FAULT_N-1:0] rawFault;

  // rails: qualified by run enable
  for (genvar r = 0; r < NUM_RAILS; r++) begin : g_rail
    assign rawFault[r] = runEnable & ~railGood[r];
  end

  assign rawFault[BUS_IDX] = busLost;

  // sensors: strictly above trip level
  for (genvar s = 0; s < NUM_SENSORS; s++) begin : g_sensor
    assign rawFault[BUS_IDX+1+s] = (tempIn[s] > tripLevel[s]);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) faultVec <= '0;
    else       faultVec <= rawFault;
  end

  logic [CODE_W-1:0] nextCode;
  err_class_e        nextClass;

  always_comb begin
    nextCode  = CODE_W'(ctl.selIdx) + CODE_W'(1);
    nextClass = (int'(ctl.selIdx) <= BUS_IDX) ? CLS_FATAL : CLS_THERMAL;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      errCode  <= '0;
      errClass <= CLS_NONE;
    end else if (ctl.capture) begin
      errCode  <= nextCode;
      errClass <= nextClass;
    end
  end

endmodule

// File: rtl/fault_control.sv
`timescale 1ns/1ps
module fault_control
  import fault_mon_pkg::*;
#(
  parameter int FAULT_N = 7
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic [FAULT_N-1:0] faultVec,
  output latch_ctl_t         ctl,
  output logic               shutdownReq
);

  typedef enum logic {ST_ARMED, ST_HELD} mon_state_e;

  mon_state_e state;
  logic             anyHit;
  logic [SEL_W-1:0] winIdx;

  // lowest index wins
  always_comb begin
    anyHit = 1'b0;
    winIdx = '0;
    for (int i = FAULT_N - 1; i >= 0; i--) begin
      if (faultVec[i]) begin
        anyHit = 1'b1;
        winIdx = SEL_W'(i);
      end
    end
  end

  always_comb begin
    ctl.capture = (state == ST_ARMED) && anyHit;
    ctl.selIdx  = winIdx;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      state       <= ST_ARMED;
      shutdownReq <= 1'b0;
    end else begin
      if (ctl.capture) state <= ST_HELD;
      shutdownReq <= (state == ST_HELD);
    end
  end

endmodule

// File: rtl/rail_thermal_monitor.sv
`timescale 1ns/1ps
module rail_thermal_monitor
  import fault_mon_pkg::*;
#(
  parameter int NUM_RAILS   = 3,
  parameter int NUM_SENSORS = 3,
  parameter int TEMP_W      = 8,
  parameter int CODE_W      = 8
) (
  input  logic                               clk,
  input  logic                               rstN,
  input  logic                               runEnable,
  input  logic [NUM_RAILS-1:0]               railGood,
  input  logic                               busLost,
  input  logic [NUM_SENSORS-1:0][TEMP_W-1:0] tempIn,
  input  logic [NUM_SENSORS-1:0][TEMP_W-1:0] tripLevel,
  output logic [CODE_W-1:0]                  errCode,
  output logic [1:0]                         errClass,
  output logic                               shutdownReq
);

  localparam int FAULT_N = NUM_RAILS + 1 + NUM_SENSORS;

  latch_ctl_t         ctl;
  logic [FAULT_N-1:0] faultVec;

  fault_datapath #(
    .NUM_RAILS(NUM_RAILS), .NUM_SENSORS(NUM_SENSORS),
    .TEMP_W(TEMP_W), .CODE_W(CODE_W)
  ) u_dp (
    .clk(clk), .rstN(rstN), .runEnable(runEnable), .railGood(railGood),
    .busLost(busLost), .tempIn(tempIn), .tripLevel(tripLevel), .ctl(ctl),
    .faultVec(faultVec), .errCode(errCode), .errClass(errClass)
  );

  fault_control #(.FAULT_N(FAULT_N)) u_ctl (
    .clk(clk), .rstN(rstN), .faultVec(faultVec), .ctl(ctl),
    .shutdownReq(shutdownReq)
  );

endmodule

// File: rtl/fault_monitor_chk.sv
`timescale 1ns/1ps
module fault_monitor_chk #(
  parameter int NUM_RAILS = 3,
  parameter int CODE_W    = 8
) (
  input logic              clk,
  input logic              rstN,
  input logic [CODE_W-1:0] errCode,
  input logic [1:0]        errClass,
  input logic              shutdownReq
);

  localparam int LAST_FATAL = NUM_RAILS + 1;

  // R7
  code_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    errCode != '0 |=> $stable(errCode) && $stable(errClass));

  // R8
  shutdown_follows_chk: assert property (@(posedge clk) disable iff (!rstN)
    errCode != '0 |=> shutdownReq);

  // R8
  shutdown_cause_chk: assert property (@(posedge clk) disable iff (!rstN)
    shutdownReq |-> $past(errCode) != '0);

  // R2
  fatal_class_chk: assert property (@(posedge clk) disable iff (!rstN)
    (errCode != '0 && int'(errCode) <= LAST_FATAL) |-> errClass == 2'd1);

  // R4
  thermal_class_chk: assert property (@(posedge clk) disable iff (!rstN)
    (int'(errCode) > LAST_FATAL) |-> errClass == 2'd2);

  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rstN)
    errCode == '0 |-> errClass == 2'd0 && !shutdownReq);

endmodule

bind rail_thermal_monitor fault_monitor_chk #(
  .NUM_RAILS(NUM_RAILS), .CODE_W(CODE_W)
) u_chk (
  .clk(clk), .rstN(rstN), .errCode(errCode), .errClass(errClass),
  .shutdownReq(shutdownReq)
);

// File: tb/sim_rail_thermal_monitor.sv
`timescale 1ns/1ps
module sim_rail_thermal_monitor;

  logic            clk = 1'b0;
  logic            rstN;
  logic            runEnable;
  logic [2:0]      railGood;
  logic            busLost;
  logic [2:0][7:0] tempIn;
  logic [2:0][7:0] tripLevel;
  logic [7:0]      errCode;
  logic [1:0]      errClass;
  logic            shutdownReq;

  int checks = 0;
  int errors = 0;
  bit done   = 1'b0;

  always #2 clk = ~clk;

  rail_thermal_monitor u0 (
    .clk(clk), .rstN(rstN), .runEnable(runEnable), .railGood(railGood),
    .busLost(busLost), .tempIn(tempIn), .tripLevel(tripLevel),
    .errCode(errCode), .errClass(errClass), .shutdownReq(shutdownReq)
  );

  function automatic logic [7:0] expCode(logic run, logic [2:0] rg, logic bl,
                                         logic [2:0][7:0] t, logic [2:0][7:0] th);
    for (int i = 0; i < 3; i++) if (run && !rg[i]) return 8'(i + 1);
    if (bl) return 8'h04;
    for (int i = 0; i < 3; i++) if (t[i] > th[i]) return 8'(i + 5);
    return 8'h00;
  endfunction

  function automatic logic [1:0] expClass(logic [7:0] c);
    if (c == 8'h00) return 2'd0;
    if (c <= 8'h04) return 2'd1;
    return 2'd2;
  endfunction

  task automatic check(string req, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic quiet();
    runEnable = 1'b1; railGood = 3'b111; busLost = 1'b0;
    tempIn = '0; tripLevel = {8'd200, 8'd200, 8'd200};
  endtask

  task automatic doReset();
    @(negedge clk);
    rstN = 1'b0;
    quiet();
    repeat (2) @(negedge clk);
    rstN = 1'b1;
  endtask

  // inputs already set at a negedge; wait two edges and check code, then shutdown
  task automatic expectLatch(string req, logic [7:0] code);
    repeat (2) @(posedge clk);
    @(negedge clk);
    check(req, errCode, code);
    check(req, errClass, expClass(code));
    check("R8", shutdownReq, 1'b0);
    @(posedge clk); @(negedge clk);
    check("R8", shutdownReq, code != 8'h00);
  endtask

  initial begin
    rstN = 1'b0;
    quiet();
    doReset();
    // R1
    check("R1", errCode, 8'h00);
    check("R1", errClass, 2'd0);
    check("R1", shutdownReq, 1'b0);

    // R2 each rail
    for (int i = 0; i < 3; i++) begin
      doReset();
      railGood[i] = 1'b0;
      expectLatch("R2", 8'(i + 1));
    end

    // R3 bus lost, run low
    doReset();
    runEnable = 1'b0; busLost = 1'b1;
    expectLatch("R3", 8'h04);

    // R4 each sensor, equality first
    for (int i = 0; i < 3; i++) begin
      doReset();
      tripLevel[i] = 8'd90; tempIn[i] = 8'd90;
      repeat (4) @(negedge clk);
      check("R4", errCode, 8'h00);
      tempIn[i] = 8'd91;
      expectLatch("R4", 8'(i + 5));
    end

    // R5 power-good ignored while run low
    doReset();
    runEnable = 1'b0; railGood = 3'b000;
    repeat (5) @(negedge clk);
    check("R5", errCode, 8'h00);
    check("R5", shutdownReq, 1'b0);
    railGood = 3'b111;
    @(negedge clk);
    runEnable = 1'b1;
    repeat (4) @(negedge clk);
    check("R5", errCode, 8'h00);

    // R6 simultaneous: GPU rail, bus, edram -> 0x03
    doReset();
    railGood[2] = 1'b0; busLost = 1'b1; tempIn[2] = 8'd255;
    expectLatch("R6", 8'h03);

    // R7 later lower-code fault does not overwrite
    doReset();
    tempIn[1] = 8'd250;
    expectLatch("R7", 8'h06);
    railGood[0] = 1'b0;
    repeat (4) @(negedge clk);
    check("R7", errCode, 8'h06);
    check("R7", errClass, 2'd2);

    // R6 R7 random vectors
    for (int n = 0; n < 300; n++) begin
      logic [7:0] ec;
      doReset();
      runEnable = 1'($urandom % 4 != 0);
      for (int i = 0; i < 3; i++) begin
        railGood[i]  = 1'($urandom % 6 != 0);
        tempIn[i]    = 8'($urandom);
        tripLevel[i] = 8'($urandom % 2 == 0 ? 8'd255 : $urandom);
      end
      busLost = 1'($urandom % 8 == 0);
      ec = expCode(runEnable, railGood, busLost, tempIn, tripLevel);
      expectLatch("R6", ec);
      quiet();
      busLost = 1'b1;
      repeat (3) @(negedge clk);
      check("R7", errCode, ec == 8'h00 ? 8'h04 : ec);
    end

    done = 1'b1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    process::self().srandom(32'd12345);
  end

  initial begin
    #1600000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

endmodule